// File: doc/BRIEF.md
# Shared Pin Mode Controller with Pin-Driven Shutdown

This block owns one device pad that can serve three roles: an active-high enable input, an open-drain output for a pattern stream, or a general-purpose I/O. A small register file sits behind a plain write/read bus. The pin-mode register picks the role. Other registers hold two brightness codes and a channel-pairing option. The pattern stream comes from a separate engine. This block only decides whether that stream reaches the pad.

While the pad is in enable mode, a sustained low level on it puts the device into global shutdown. The input first passes through a synchronizer. A qualification counter then has to see the synchronized low on two consecutive edges. During shutdown every register returns to its default, bus writes have no effect, reads return defaults, and every output-driver enable is released. The mode register is one of the registers that shutdown clears, so the register decides whether its own reset path is open.

The open-drain pad is modelled as an output enable that pulls the line low. A pad value of 1 means the line is released.

Top module: `pm_pin_ctrl`

## Requirements
- R1: After reset all registers hold zero, so the pad is in enable mode. `shutdown`, `pin_oe`, `pin_out`, `sink_oe` and both channel codes are 0. With the pad high, a read of address 0x80 returns 0x10.
- R2: The pin-mode register is at address 0x80 and stores write bits [3:0]. A read returns those bits in [3:0] and the synchronized pad level in bit 4. Bits [7:5] read 0. Bit 0 = 0 selects enable mode. Bit 0 = 1 selects bit 1: pattern (1) or general-purpose (0).
- R3: In enable mode `pin_oe` is 0. Shutdown can assert only on an edge after the register has already held enable mode.
- R4: Shutdown asserts on the fourth rising edge after `pin_in` falls and stays low. It deasserts on the third rising edge after `pin_in` returns high. A low pulse lasting a single cycle causes no shutdown.
- R5: Shutdown returns every register to zero.
- R6: While `shutdown` is 1, bus writes have no effect and every read returns 0. This includes a write issued on the same edge at which shutdown asserts.
- R7: While `shutdown` is 1, `pin_oe`, `pin_out` and both `sink_oe` bits are 0.
- R8: A low pad level causes no shutdown while bit 0 of the mode register is 1.
- R9: In pattern mode `pin_oe` is the inverse of `pat_bit` and `pin_out` is 0. The pad is pulled low only when the pattern bit is 0.
- R10: In general-purpose mode, `pin_oe` follows mode bit 3 (1 = output) and `pin_out` follows mode bit 2.
- R11: Bit 2 of the register at 0x10 is the unison bit. All other bits of that register read 0. Channel A's code comes from 0xA0. Channel B's code comes from 0xA1 when unison is 0, and from 0xA0 when unison is 1.
- R12: `sink_oe[0]` is 1 when channel A's code is nonzero, and `sink_oe[1]` is 1 when channel B's code is nonzero, both outside shutdown.
- R13: The brightness registers store 7 bits, so bit 7 reads 0. Any unmapped address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 1 | Level seen at the shared pad |
| pat_bit | input | 1 | Current bit from the pattern engine |
| pin_oe | output | 1 | Pad driver enable |
| pin_out | output | 1 | Pad driven level; 0 in the open-drain modes |
| shutdown | output | 1 | Global shutdown indication |
| ch_a_code | output | 7 | Brightness code for sink channel A |
| ch_b_code | output | 7 | Brightness code for sink channel B |
| sink_oe | output | 2 | Sink driver enables: [0] channel A, [1] channel B |

## Verification
Two functions can land on the same clock edge: a bus write, and the edge at which qualified shutdown first asserts. The bench provokes this by dropping the pad in enable mode and timing a brightness write so that its strobe is sampled on the fourth edge after the fall. The write lands one cycle before the clear. After the pad is released, a read of that register must return 0.

A second collision comes from a mode write that enters enable mode while the pad is already low. Shutdown must wait one further edge, and that delay is checked cycle by cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;

   typedef enum logic [1:0] {
      PM_HWEN    = 2'd0,
      PM_GPIO    = 2'd1,
      PM_PATTERN = 2'd2
   } pin_role_e;

   // bit0 = 0 -> enable input; else bit1 picks pattern (1) or gpio (0)
   function automatic pin_role_e decode_role(input logic [1:0] sel);
      if (!sel[0])
         return PM_HWEN;
      else if (sel[1])
         return PM_PATTERN;
      else
         return PM_GPIO;
   endfunction

   localparam int MODE_BITS = 4;
   localparam int LVL_BIT   = 4;
   localparam int UNI_BIT   = 2;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain_q[s] <= RST_VAL;
            else if (s == 0)
               chain_q[s] <= d;
            else
               chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pm_sd_detect.sv
module pm_sd_detect #(
   parameter int CONFIRM = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_lvl,
   input  logic hwen_mode,
   output logic sd
);

   generate
      if (CONFIRM < 1) begin : g_bad_confirm
         $error("pm_sd_detect: CONFIRM must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(CONFIRM + 1);

   logic [CW-1:0] low_cnt_q;
   logic          sat;

   assign sat = (low_cnt_q >= CW'(CONFIRM - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         sd        <= 1'b0;
      end else begin
         if (pin_lvl)
            low_cnt_q <= '0;
         else if (low_cnt_q != CW'(CONFIRM))
            low_cnt_q <= low_cnt_q + 1'b1;
         sd <= hwen_mode && !pin_lvl && sat;
      end
   end

endmodule

// File: rtl/pm_regfile.sv
module pm_regfile
   import pm_pkg::*;
#(
   parameter int              AW        = 8,
   parameter int              DW        = 8,
   parameter int              BRT_W     = 7,
   parameter logic [AW-1:0]   ADDR_MODE = 8'h80,
   parameter logic [AW-1:0]   ADDR_GP   = 8'h10,
   parameter logic [AW-1:0]   ADDR_BRA  = 8'hA0,
   parameter logic [AW-1:0]   ADDR_BRB  = 8'hA1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        wdata,
   input  logic                 pin_lvl,
   output logic [DW-1:0]        rdata,
   output logic [MODE_BITS-1:0] mode_bits,
   output logic                 unison,
   output logic [BRT_W-1:0]     brt_a,
   output logic [BRT_W-1:0]     brt_b
);

   generate
      if (DW <= LVL_BIT || BRT_W > DW) begin : g_bad_width
         $error("pm_regfile: DW too narrow for the register layout");
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_bits <= '0;
         unison    <= 1'b0;
         brt_a     <= '0;
         brt_b     <= '0;
      end else if (clr) begin
         mode_bits <= '0;
         unison    <= 1'b0;
         brt_a     <= '0;
         brt_b     <= '0;
      end else if (wr) begin
         if (addr == ADDR_MODE) mode_bits <= wdata[MODE_BITS-1:0];
         if (addr == ADDR_GP)   unison    <= wdata[UNI_BIT];
         if (addr == ADDR_BRA)  brt_a     <= wdata[BRT_W-1:0];
         if (addr == ADDR_BRB)  brt_b     <= wdata[BRT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (!clr) begin
         if (addr == ADDR_MODE) begin
            rdata[MODE_BITS-1:0] = mode_bits;
            rdata[LVL_BIT]       = pin_lvl;
         end else if (addr == ADDR_GP) begin
            rdata[UNI_BIT] = unison;
         end else if (addr == ADDR_BRA) begin
            rdata[BRT_W-1:0] = brt_a;
         end else if (addr == ADDR_BRB) begin
            rdata[BRT_W-1:0] = brt_b;
         end
      end
   end

endmodule

// File: rtl/pm_pin_mux.sv
module pm_pin_mux
   import pm_pkg::*;
(
   input  logic [MODE_BITS-1:0] mode_bits,
   input  logic                 pat_bit,
   input  logic                 sd,
   output logic                 pin_oe,
   output logic                 pin_out
);

   pin_role_e role;

   assign role = decode_role(mode_bits[1:0]);

   always_comb begin
      pin_oe  = 1'b0;
      pin_out = 1'b0;
      if (!sd) begin
         unique case (role)
            PM_PATTERN: pin_oe = !pat_bit;
            PM_GPIO: begin
               pin_oe  = mode_bits[3];
               pin_out = mode_bits[2];
            end
            default: pin_oe = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/pm_pin_ctrl.sv
module pm_pin_ctrl
   import pm_pkg::*;
#(
   parameter int            AW          = 8,
   parameter int            DW          = 8,
   parameter int            BRT_W       = 7,
   parameter int            SYNC_STAGES = 2,
   parameter int            CONFIRM     = 2,
   parameter int            N_SINK      = 2,
   parameter logic [AW-1:0] ADDR_MODE   = 8'h80,
   parameter logic [AW-1:0] ADDR_GP     = 8'h10,
   parameter logic [AW-1:0] ADDR_BRA    = 8'hA0,
   parameter logic [AW-1:0] ADDR_BRB    = 8'hA1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              pin_in,
   input  logic              pat_bit,
   output logic              pin_oe,
   output logic              pin_out,
   output logic              shutdown,
   output logic [BRT_W-1:0]  ch_a_code,
   output logic [BRT_W-1:0]  ch_b_code,
   output logic [N_SINK-1:0] sink_oe
);

   generate
      if (N_SINK != 2) begin : g_bad_sinks
         $error("pm_pin_ctrl: exactly two sink channels are supported");
      end
   endgenerate

   logic                 pin_lvl;
   logic                 sd;
   logic [MODE_BITS-1:0] mode_bits;
   logic                 unison;
   logic [BRT_W-1:0]     brt_a;
   logic [BRT_W-1:0]     brt_b;
   logic [BRT_W-1:0]     code_q [N_SINK];

   pm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_lvl)
   );

   pm_sd_detect #(.CONFIRM(CONFIRM)) sd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_lvl   (pin_lvl),
      .hwen_mode (decode_role(mode_bits[1:0]) == PM_HWEN),
      .sd        (sd)
   );

   pm_regfile #(
      .AW(AW), .DW(DW), .BRT_W(BRT_W),
      .ADDR_MODE(ADDR_MODE), .ADDR_GP(ADDR_GP),
      .ADDR_BRA(ADDR_BRA), .ADDR_BRB(ADDR_BRB)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (sd),
      .wr        (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .pin_lvl   (pin_lvl),
      .rdata     (bus_rdata),
      .mode_bits (mode_bits),
      .unison    (unison),
      .brt_a     (brt_a),
      .brt_b     (brt_b)
   );

   pm_pin_mux mux_i (
      .mode_bits (mode_bits),
      .pat_bit   (pat_bit),
      .sd        (sd),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out)
   );

   assign code_q[0] = brt_a;
   assign code_q[1] = unison ? brt_a : brt_b;

   generate
      for (genvar c = 0; c < N_SINK; c++) begin : g_sink
         assign sink_oe[c] = !sd && (code_q[c] != '0);
      end
   endgenerate

   assign ch_a_code = code_q[0];
   assign ch_b_code = code_q[1];
   assign shutdown  = sd;

endmodule

// File: rtl/pm_pin_ctrl_chk.sv
module pm_pin_ctrl_chk #(
   parameter int BRT_W = 7,
   parameter int DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shutdown,
   input logic             pin_oe,
   input logic             pin_out,
   input logic [1:0]       sink_oe,
   input logic [BRT_W-1:0] ch_a_code,
   input logic [BRT_W-1:0] ch_b_code,
   input logic [DW-1:0]    bus_rdata,
   input logic [3:0]       mode_bits,
   input logic             unison,
   input logic             pat_bit
);

   // R7
   sd_drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!pin_oe && !pin_out && sink_oe == 2'b00));

   // R5
   sd_clears_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> (mode_bits == 4'h0 && !unison && ch_a_code == '0 && ch_b_code == '0));

   // R6
   sd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (bus_rdata == '0));

   // R8
   sd_needs_hwen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> $past(mode_bits[0] == 1'b0));

   // R3
   hwen_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bits[0] == 1'b0) |-> !pin_oe);

   // R9
   pattern_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shutdown && mode_bits[1:0] == 2'b11) |-> (pin_oe == !pat_bit && !pin_out));

   // R11
   unison_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unison |-> (ch_b_code == ch_a_code));

endmodule

bind pm_pin_ctrl pm_pin_ctrl_chk #(.BRT_W(BRT_W), .DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .shutdown  (shutdown),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .sink_oe   (sink_oe),
   .ch_a_code (ch_a_code),
   .ch_b_code (ch_b_code),
   .bus_rdata (bus_rdata),
   .mode_bits (mode_bits),
   .unison    (unison),
   .pat_bit   (pat_bit)
);

// File: tb/pm_pin_ctrl_tb_top.sv
module pm_pin_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       pin_in = 1'b1;
   logic       pat_bit = 1'b0;
   logic       pin_oe;
   logic       pin_out;
   logic       shutdown;
   logic [6:0] ch_a_code;
   logic [6:0] ch_b_code;
   logic [1:0] sink_oe;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pm_pin_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pat_bit   (pat_bit),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out),
      .shutdown  (shutdown),
      .ch_a_code (ch_a_code),
      .ch_b_code (ch_b_code),
      .sink_oe   (sink_oe)
   );

   typedef struct packed {
      logic [3:0] req;
      logic [7:0] addr;
      logic [7:0] wdata;
      logic       pat;
      logic [7:0] exp_rd;
      logic       exp_oe;
      logic       exp_out;
      logic [6:0] exp_chb;
      logic [1:0] exp_sink;
   } vec_t;

   // req, addr, wdata, pat, rdata, oe, out, ch_b, sink
   localparam vec_t VECS [13] = '{
      '{4'd10, 8'h80, 8'h01, 1'b0, 8'h11, 1'b0, 1'b0, 7'h00, 2'b00}, // R10 gpio input
      '{4'd10, 8'h80, 8'h0D, 1'b0, 8'h1D, 1'b1, 1'b1, 7'h00, 2'b00}, // R10 drive high
      '{4'd10, 8'h80, 8'h09, 1'b0, 8'h19, 1'b1, 1'b0, 7'h00, 2'b00}, // R10 drive low
      '{4'd9,  8'h80, 8'h03, 1'b0, 8'h13, 1'b1, 1'b0, 7'h00, 2'b00}, // R9 pattern 0
      '{4'd9,  8'h80, 8'h03, 1'b1, 8'h13, 1'b0, 1'b0, 7'h00, 2'b00}, // R9 pattern 1
      '{4'd2,  8'h80, 8'hF3, 1'b1, 8'h13, 1'b0, 1'b0, 7'h00, 2'b00}, // R2 upper bits
      '{4'd13, 8'hA0, 8'h85, 1'b1, 8'h05, 1'b0, 1'b0, 7'h00, 2'b01}, // R13 7-bit code
      '{4'd11, 8'hA1, 8'h22, 1'b1, 8'h22, 1'b0, 1'b0, 7'h22, 2'b11}, // R11 separate
      '{4'd11, 8'h10, 8'hFF, 1'b1, 8'h04, 1'b0, 1'b0, 7'h05, 2'b11}, // R11 unison on
      '{4'd11, 8'h10, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 7'h22, 2'b11}, // R11 unison off
      '{4'd12, 8'hA0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 7'h22, 2'b10}, // R12 A zero
      '{4'd12, 8'h10, 8'h04, 1'b1, 8'h04, 1'b0, 1'b0, 7'h00, 2'b00}, // R12 shared zero
      '{4'd13, 8'h55, 8'h12, 1'b1, 8'h00, 1'b0, 1'b0, 7'h00, 2'b00}  // R13 unmapped
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      check(tag, 32'(bus_rdata), 32'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(3);

      // R1 reset state
      check("R1 shutdown", 32'(shutdown), 0);
      check("R1 pin_oe", 32'(pin_oe), 0);
      check("R1 sink_oe", 32'(sink_oe), 0);
      check("R1 ch_a", 32'(ch_a_code), 0);
      rd("R1 mode read", 8'h80, 8'h10);

      for (int v = 0; v < 13; v++) begin
         pat_bit = VECS[v].pat;
         wr(VECS[v].addr, VECS[v].wdata);
         rd($sformatf("R%0d vec%0d rdata", VECS[v].req, v), VECS[v].addr, VECS[v].exp_rd);
         check($sformatf("R%0d vec%0d pin_oe", VECS[v].req, v), 32'(pin_oe), 32'(VECS[v].exp_oe));
         check($sformatf("R%0d vec%0d pin_out", VECS[v].req, v), 32'(pin_out), 32'(VECS[v].exp_out));
         check($sformatf("R%0d vec%0d ch_b", VECS[v].req, v), 32'(ch_b_code), 32'(VECS[v].exp_chb));
         check($sformatf("R%0d vec%0d sink_oe", VECS[v].req, v), 32'(sink_oe), 32'(VECS[v].exp_sink));
      end

      // R8 low pad outside enable mode
      wr(8'h80, 8'h01);
      pin_in = 1'b0;
      cycles(8);
      check("R8 no shutdown", 32'(shutdown), 0);
      rd("R8 mode kept", 8'h80, 8'h01);

      // R3 entering enable mode with pad already low
      wr(8'h80, 8'h00);
      check("R3 not yet", 32'(shutdown), 0);
      cycles(1);
      check("R3 shutdown after mode", 32'(shutdown), 1);
      pin_in = 1'b1;
      cycles(4);
      check("R3 released", 32'(shutdown), 0);

      // R4 R5 R6 R7 main shutdown sequence
      wr(8'hA0, 8'h11);
      wr(8'hA1, 8'h22);
      wr(8'h10, 8'h00);
      check("R12 both on", 32'(sink_oe), 3);
      pin_in = 1'b0;
      cycles(3);
      check("R4 not after 3 edges", 32'(shutdown), 0);
      cycles(1);
      check("R4 on 4th edge", 32'(shutdown), 1);
      check("R7 sinks off", 32'(sink_oe), 0);
      check("R7 pin_oe off", 32'(pin_oe), 0);
      rd("R6 read zero", 8'hA0, 8'h00);
      wr(8'hA0, 8'h33);
      cycles(2);
      pin_in = 1'b1;
      cycles(2);
      check("R4 held 2 edges", 32'(shutdown), 1);
      cycles(1);
      check("R4 off 3rd edge", 32'(shutdown), 0);
      rd("R5 A cleared", 8'hA0, 8'h00);
      rd("R5 B cleared", 8'hA1, 8'h00);
      check("R5 ch_b", 32'(ch_b_code), 0);
      wr(8'hA0, 8'h33);
      rd("R6 writes resume", 8'hA0, 8'h33);

      // R4 one-cycle glitch
      pin_in = 1'b0;
      cycles(1);
      pin_in = 1'b1;
      for (int i = 0; i < 6; i++) begin
         cycles(1);
         check("R4 glitch ignored", 32'(shutdown), 0);
      end
      rd("R4 regs kept", 8'hA0, 8'h33);

      // R6 write on the edge where shutdown asserts
      wr(8'hA0, 8'h44);
      pin_in = 1'b0;
      cycles(3);
      wr(8'hA0, 8'h55);
      check("R6 collide sd", 32'(shutdown), 1);
      cycles(2);
      pin_in = 1'b1;
      cycles(4);
      rd("R6 collided write lost", 8'hA0, 8'h00);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule